// File: doc/BRIEF.md
# Flash command interface with block locking

This block is a synchronous model of the command decoder and write state machine of a byte-wide, block-erasable flash memory. Bus write cycles arrive as an address, a data byte and a one-cycle write strobe. The decoder turns single- and multi-cycle command sequences into read-mode changes, lock and protection updates, and jobs for the write state machine. The machine runs byte programming, two-byte programming, single-block erase and erase of all unlocked blocks, each for a fixed number of clock cycles. A block erase can be suspended so that other blocks can be read, and then resumed.

The array has 2^NBLK_W blocks (16 by default). A behavioural byte array is included so that results can be read back. The array is 16 bytes per block by default. Setting OFS_W to 14 gives full 16K-byte blocks, with the block number in address bits 17:14.

Every block has a lock bit. A protection switch decides whether the lock bits are enforced. After reset all blocks refuse programming and single-block erase. This lasts until either the protect-set sequence or an erase-all sequence runs, and both of them switch enforcement of the real lock bits on.

Opcodes:

| Opcode | Action |
|---|---|
| 0xFF | Read array |
| 0x70 | Read status |
| 0x90 | Read identifier |
| 0x50 | Clear status |
| 0x40 | Program byte (setup) |
| 0xFB | Program two bytes (setup) |
| 0x20 | Block erase (setup) |
| 0xA7 | Erase all unlocked blocks (setup) |
| 0x77 | Set the lock bit of a block (setup) |
| 0x57 | Protection on (setup) |
| 0x47 | Protection off (setup) |
| 0xD0 | Confirm, and resume a suspended erase |
| 0xB0 | Suspend an erase |

Top module: `flash_cmd_if`

## Requirements
- R1: The upper NBLK_W address bits select the block and the lower OFS_W bits select the byte in it. An erase changes only the bytes of the addressed block.
- R2: After reset the read mode is array. The read mode is chosen as follows:
  - 0xFF selects array data.
  - 0x70 selects status.
  - 0x90 selects the identifier, which is 0xB0 when address bit 0 is 0 and 0x30 when it is 1.
- R3: Byte programming is 0x40 followed by one data cycle at the target address. The byte becomes old AND new. busy_o is high for exactly WR_CYC cycles.
- R4: While busy_o is high:
  - rdata_o shows status, with bit 7 low.
  - Every bus write other than 0xB0 is ignored and leaves the array unchanged.
- R5: Block erase is 0x20 followed by 0xD0 at an address inside the block. It sets every byte of that block to 0xFF over 2^OFS_W busy cycles. Any confirm byte other than 0xD0 starts nothing and sets status bits 5 and 4.
- R6: Two-byte programming is 0xFB, then a data cycle for the first byte, then a data cycle for the second byte, each at its own address. busy_o is high for 2*WR_CYC cycles.
- R7: 0xB0 during an erase suspends it. Status then reads 0xC0 (bit 7 ready, bit 6 suspended) and other blocks read normally. 0xD0 resumes the erase, which then completes.
- R8: After reset every block refuses programming, which sets status bit 4, and refuses single-block erase, which sets status bit 5. This holds until 0x57/0xD0 or an erase-all runs.
- R9: 0x77/0xD0 sets the lock bit of the addressed block. With protection on (0x57/0xD0), programming a locked block is refused. Protection off (0x47/0xD0) lets it through.
- R10: Erase-all (0xA7/0xD0) is accepted right after reset. It skips every block whose lock bit is set, spending one cycle per skipped block, and erases the others. It also ends the reset lockout with protection on.
- R11: With vpp_i low, program and erase change nothing. A program sets status bits 4 and 3; an erase sets status bits 5 and 3.
- R12: Status bits 5, 4 and 3 stay set until 0x50 clears them.
- R13: Right after reset:
  - busy_o is low.
  - Status reads 0x80.
  - Every array byte reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | One-cycle bus write strobe |
| addr_i | input | NBLK_W+OFS_W | Bus address for writes and reads |
| data_i | input | 8 | Command or data byte |
| vpp_i | input | 1 | Programming supply good |
| rdata_o | output | 8 | Array, status or identifier byte |
| busy_o | output | 1 | Write state machine running |

## Verification
The hardest state to reach is an erase suspended part-way through, with a different block read and a later resume that must still finish the erase. The stimulus issues 0xB0 a few cycles after the erase confirm, while busy_o is still high. It then switches to array reads of a block programmed earlier, idles, and resumes. A second hard case is erase-all at power-up: the array is all ones, so the skipped locked block is seen only through the busy cycle count. Refusals are then checked through later program attempts.

// File: rtl/fci_pkg.sv
package fci_pkg;
  localparam logic [7:0] CMD_READ  = 8'hFF;
  localparam logic [7:0] CMD_ID    = 8'h90;
  localparam logic [7:0] CMD_STAT  = 8'h70;
  localparam logic [7:0] CMD_CLR   = 8'h50;
  localparam logic [7:0] CMD_PROG  = 8'h40;
  localparam logic [7:0] CMD_PROG2 = 8'hFB;
  localparam logic [7:0] CMD_ERASE = 8'h20;
  localparam logic [7:0] CMD_ERALL = 8'hA7;
  localparam logic [7:0] CMD_LOCK  = 8'h77;
  localparam logic [7:0] CMD_PSET  = 8'h57;
  localparam logic [7:0] CMD_PCLR  = 8'h47;
  localparam logic [7:0] CMD_CONF  = 8'hD0;
  localparam logic [7:0] CMD_SUSP  = 8'hB0;

  localparam logic [7:0] ID_MFR = 8'hB0;
  localparam logic [7:0] ID_DEV = 8'h30;

  localparam int ST_RDY   = 7;
  localparam int ST_SUS   = 6;
  localparam int ST_ERR_E = 5;
  localparam int ST_ERR_W = 4;
  localparam int ST_VPP   = 3;

  typedef enum logic [1:0] {RD_ARRAY, RD_STAT, RD_ID} rd_mode_e;
  typedef enum logic [1:0] {JOB_PROG, JOB_ERASE, JOB_ERALL} job_e;

  typedef struct packed {
    logic ers;
    logic wr;
    logic vpp;
  } err_t;
endpackage

// File: rtl/fci_array.sv
module fci_array #(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              ers_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [7:0]        wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [7:0]        rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
    end else if (we_i) begin
      // programming can only clear bits; erase sets the byte to ones
      mem_q[waddr_i] <= ers_i ? 8'hFF : (mem_q[waddr_i] & wdata_i);
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/fci_cmd.sv
module fci_cmd
  import fci_pkg::*;
#(
  parameter int NBLK_W = 4,
  parameter int OFS_W  = 4,
  parameter logic [(1<<NBLK_W)-1:0] LOCK_INIT = '0,
  localparam int ADDR_W = NBLK_W + OFS_W,
  localparam int NBLK   = 1 << NBLK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  input  logic              vpp_i,
  input  logic              busy_i,
  input  logic              susp_i,
  output logic              go_o,
  output job_e              job_o,
  output logic              two_o,
  output logic [ADDR_W-1:0] a0_o,
  output logic [7:0]        d0_o,
  output logic [ADDR_W-1:0] a1_o,
  output logic [7:0]        d1_o,
  output logic [NBLK-1:0]   skip_o,
  output err_t              err_o,
  output logic              clr_o,
  output logic              susp_req_o,
  output logic              resume_o,
  output rd_mode_e          mode_o,
  output logic [NBLK-1:0]   eff_lock_o
);
  typedef enum logic [3:0] {
    C_IDLE, C_PROG, C_P2A, C_P2B, C_ERASE, C_ERALL, C_LOCK, C_PSET, C_PCLR
  } cstate_e;

  cstate_e           st_q, st_d;
  rd_mode_e          mode_q, mode_d;
  logic [NBLK-1:0]   lock_q, lock_d;
  logic              pwr_q, pwr_d;   // reset lockout
  logic              prot_q, prot_d;
  logic [ADDR_W-1:0] a0_q, a0_d;
  logic [7:0]        d0_q, d0_d;
  logic [NBLK-1:0]   eff_lock;
  logic [NBLK_W-1:0] blk_cur, blk_prev;

  assign eff_lock   = {NBLK{pwr_q}} | ({NBLK{prot_q}} & lock_q);
  assign eff_lock_o = eff_lock;
  assign blk_cur    = addr_i[ADDR_W-1:OFS_W];
  assign blk_prev   = a0_q[ADDR_W-1:OFS_W];
  assign skip_o     = lock_q & {NBLK{pwr_q | prot_q}};
  assign mode_o     = mode_q;
  assign a0_o       = (st_q == C_P2B) ? a0_q : addr_i;
  assign d0_o       = (st_q == C_P2B) ? d0_q : data_i;
  assign a1_o       = addr_i;
  assign d1_o       = data_i;

  always_comb begin
    st_d = st_q; mode_d = mode_q; lock_d = lock_q; pwr_d = pwr_q; prot_d = prot_q;
    a0_d = a0_q; d0_d = d0_q;
    go_o = 1'b0; job_o = JOB_PROG; two_o = 1'b0; err_o = '0;
    clr_o = 1'b0; susp_req_o = 1'b0; resume_o = 1'b0;
    if (we_i) begin
      if (busy_i) begin
        susp_req_o = (data_i == CMD_SUSP);
      end else if (susp_i) begin
        unique case (data_i)
          CMD_READ: mode_d = RD_ARRAY;
          CMD_STAT: mode_d = RD_STAT;
          CMD_ID:   mode_d = RD_ID;
          CMD_CONF: begin resume_o = 1'b1; mode_d = RD_STAT; end
          default: ;
        endcase
      end else begin
        st_d = C_IDLE;
        unique case (st_q)
          C_IDLE: begin
            unique case (data_i)
              CMD_READ:  mode_d = RD_ARRAY;
              CMD_STAT:  mode_d = RD_STAT;
              CMD_ID:    mode_d = RD_ID;
              CMD_CLR:   clr_o  = 1'b1;
              CMD_PROG:  begin st_d = C_PROG;  mode_d = RD_STAT; end
              CMD_PROG2: begin st_d = C_P2A;   mode_d = RD_STAT; end
              CMD_ERASE: begin st_d = C_ERASE; mode_d = RD_STAT; end
              CMD_ERALL: begin st_d = C_ERALL; mode_d = RD_STAT; end
              CMD_LOCK:  begin st_d = C_LOCK;  mode_d = RD_STAT; end
              CMD_PSET:  begin st_d = C_PSET;  mode_d = RD_STAT; end
              CMD_PCLR:  begin st_d = C_PCLR;  mode_d = RD_STAT; end
              default: ;
            endcase
          end
          C_PROG: begin
            if (!vpp_i)                 begin err_o.wr = 1'b1; err_o.vpp = 1'b1; end
            else if (eff_lock[blk_cur]) err_o.wr = 1'b1;
            else                        go_o = 1'b1;
          end
          C_P2A: begin
            a0_d = addr_i; d0_d = data_i; st_d = C_P2B;
          end
          C_P2B: begin
            two_o = 1'b1;
            if (!vpp_i) begin err_o.wr = 1'b1; err_o.vpp = 1'b1; end
            else if (eff_lock[blk_cur] || eff_lock[blk_prev]) err_o.wr = 1'b1;
            else go_o = 1'b1;
          end
          default: begin
            // confirm-type second cycle
            if (data_i != CMD_CONF) begin
              err_o.ers = 1'b1; err_o.wr = 1'b1;
            end else begin
              unique case (st_q)
                C_ERASE: begin
                  job_o = JOB_ERASE;
                  if (!vpp_i)                 begin err_o.ers = 1'b1; err_o.vpp = 1'b1; end
                  else if (eff_lock[blk_cur]) err_o.ers = 1'b1;
                  else                        go_o = 1'b1;
                end
                C_ERALL: begin
                  job_o = JOB_ERALL;
                  if (!vpp_i) begin err_o.ers = 1'b1; err_o.vpp = 1'b1; end
                  else begin go_o = 1'b1; pwr_d = 1'b0; prot_d = 1'b1; end
                end
                C_LOCK: begin
                  if (!vpp_i) begin err_o.wr = 1'b1; err_o.vpp = 1'b1; end
                  else lock_d[blk_cur] = 1'b1;
                end
                C_PSET: begin pwr_d = 1'b0; prot_d = 1'b1; end
                C_PCLR: prot_d = 1'b0;
                default: ;
              endcase
            end
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= C_IDLE; mode_q <= RD_ARRAY; lock_q <= LOCK_INIT;
      pwr_q <= 1'b1; prot_q <= 1'b0; a0_q <= '0; d0_q <= '0;
    end else begin
      st_q <= st_d; mode_q <= mode_d; lock_q <= lock_d;
      pwr_q <= pwr_d; prot_q <= prot_d; a0_q <= a0_d; d0_q <= d0_d;
    end
  end

  // R4: nothing starts while the machine runs
  p_no_go_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !go_o);
  // R8: during reset lockout only erase-all may start
  p_lockout_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_q && go_o) |-> (job_o == JOB_ERALL));
endmodule

// File: rtl/fci_wsm.sv
module fci_wsm
  import fci_pkg::*;
#(
  parameter int NBLK_W = 4,
  parameter int OFS_W  = 4,
  parameter int WR_CYC = 6,
  localparam int ADDR_W = NBLK_W + OFS_W,
  localparam int NBLK   = 1 << NBLK_W,
  localparam int CNT_W  = $clog2(WR_CYC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  job_e              job_i,
  input  logic              two_i,
  input  logic [ADDR_W-1:0] a0_i,
  input  logic [7:0]        d0_i,
  input  logic [ADDR_W-1:0] a1_i,
  input  logic [7:0]        d1_i,
  input  logic [NBLK-1:0]   skip_i,
  input  err_t              err_i,
  input  logic              clr_i,
  input  logic              susp_req_i,
  input  logic              resume_i,
  output logic              busy_o,
  output logic              susp_o,
  output logic [7:0]        status_o,
  output logic              mem_we_o,
  output logic              mem_ers_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_data_o
);
  typedef enum logic [1:0] {W_IDLE, W_PROG, W_ERASE, W_SUSP} wstate_e;

  localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(WR_CYC - 1);
  localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);
  localparam logic [NBLK_W-1:0] BLK_LAST = '1;
  localparam logic [NBLK_W-1:0] BLK_ONE  = NBLK_W'(1);
  localparam logic [OFS_W-1:0]  OFS_LAST = '1;
  localparam logic [OFS_W-1:0]  OFS_ONE  = OFS_W'(1);

  wstate_e           st_q, st_n;
  logic [CNT_W-1:0]  cnt_q;
  logic              second_q, all_q;
  logic [ADDR_W-1:0] cur_a_q, a1_q;
  logic [7:0]        cur_d_q, d1_q;
  logic [NBLK_W-1:0] blk_q;
  logic [OFS_W-1:0]  ofs_q;
  logic [NBLK-1:0]   skip_q;
  err_t              err_q;
  logic              skip_now, blk_done;

  assign skip_now = all_q && skip_q[blk_q];
  assign blk_done = skip_now || (ofs_q == OFS_LAST);
  assign busy_o   = (st_q == W_PROG) || (st_q == W_ERASE);
  assign susp_o   = (st_q == W_SUSP);
  assign status_o = {~busy_o, susp_o, err_q.ers, err_q.wr, err_q.vpp, 3'b000};

  always_comb begin
    mem_we_o = 1'b0; mem_ers_o = 1'b0; mem_addr_o = cur_a_q; mem_data_o = cur_d_q;
    if (st_q == W_PROG) begin
      mem_we_o = (cnt_q == CNT_LAST);
    end else if (st_q == W_ERASE) begin
      mem_we_o   = !skip_now;
      mem_ers_o  = 1'b1;
      mem_addr_o = {blk_q, ofs_q};
    end
  end

  always_comb begin
    st_n = st_q;
    unique case (st_q)
      W_IDLE:  if (go_i) st_n = (job_i == JOB_PROG) ? W_PROG : W_ERASE;
      W_PROG:  if (cnt_q == CNT_LAST && !second_q) st_n = W_IDLE;
      W_ERASE: begin
        if (blk_done && !(all_q && blk_q != BLK_LAST)) st_n = W_IDLE;
        if (susp_req_i && st_n == W_ERASE) st_n = W_SUSP;
      end
      W_SUSP:  if (resume_i) st_n = W_ERASE;
      default: st_n = W_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= W_IDLE; cnt_q <= '0; second_q <= 1'b0; all_q <= 1'b0;
      cur_a_q <= '0; cur_d_q <= '0; a1_q <= '0; d1_q <= '0;
      blk_q <= '0; ofs_q <= '0; skip_q <= '0; err_q <= '0;
    end else begin
      st_q  <= st_n;
      err_q <= clr_i ? err_t'('0) : (err_q | err_i);
      unique case (st_q)
        W_IDLE: if (go_i) begin
          cnt_q <= '0; ofs_q <= '0;
          cur_a_q <= a0_i; cur_d_q <= d0_i; a1_q <= a1_i; d1_q <= d1_i;
          second_q <= (job_i == JOB_PROG) && two_i;
          all_q    <= (job_i == JOB_ERALL);
          skip_q   <= skip_i;
          blk_q    <= (job_i == JOB_ERALL) ? '0 : a0_i[ADDR_W-1:OFS_W];
        end
        W_PROG: begin
          if (cnt_q == CNT_LAST) begin
            cnt_q <= '0;
            if (second_q) begin
              cur_a_q <= a1_q; cur_d_q <= d1_q; second_q <= 1'b0;
            end
          end else begin
            cnt_q <= cnt_q + CNT_ONE;
          end
        end
        W_ERASE: begin
          if (blk_done) begin
            ofs_q <= '0;
            if (all_q && blk_q != BLK_LAST) blk_q <= blk_q + BLK_ONE;
          end else begin
            ofs_q <= ofs_q + OFS_ONE;
          end
        end
        default: ;
      endcase
    end
  end

  p_go_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i |=> busy_o);
  p_susp_entry_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(susp_o) |-> $past(susp_req_i));
  p_susp_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (susp_o && !resume_i) |=> (susp_o && !mem_we_o));
  p_werr_sticky_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(status_o[ST_ERR_W]) |-> $past(clr_i));
  p_eerr_sticky_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(status_o[ST_ERR_E]) |-> $past(clr_i));
endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
  import fci_pkg::*;
#(
  parameter int NBLK_W = 4,
  parameter int OFS_W  = 4,
  parameter int WR_CYC = 6,
  parameter logic [(1<<NBLK_W)-1:0] LOCK_INIT = '0,
  localparam int ADDR_W = NBLK_W + OFS_W,
  localparam int NBLK   = 1 << NBLK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  input  logic              vpp_i,
  output logic [7:0]        rdata_o,
  output logic              busy_o
);
  logic              go, two, clr, susp_req, resume, busy, susp;
  job_e              job;
  logic [ADDR_W-1:0] a0, a1, mem_addr;
  logic [7:0]        d0, d1, mem_data, mem_rd, status;
  logic [NBLK-1:0]   skip, eff_lock;
  err_t              err;
  rd_mode_e          mode;
  logic              mem_we, mem_ers;

  fci_cmd #(.NBLK_W(NBLK_W), .OFS_W(OFS_W), .LOCK_INIT(LOCK_INIT)) u_cmd (
    .clk_i, .rst_ni, .we_i, .addr_i, .data_i, .vpp_i,
    .busy_i(busy), .susp_i(susp),
    .go_o(go), .job_o(job), .two_o(two), .a0_o(a0), .d0_o(d0), .a1_o(a1), .d1_o(d1),
    .skip_o(skip), .err_o(err), .clr_o(clr), .susp_req_o(susp_req), .resume_o(resume),
    .mode_o(mode), .eff_lock_o(eff_lock)
  );

  fci_wsm #(.NBLK_W(NBLK_W), .OFS_W(OFS_W), .WR_CYC(WR_CYC)) u_wsm (
    .clk_i, .rst_ni,
    .go_i(go), .job_i(job), .two_i(two), .a0_i(a0), .d0_i(d0), .a1_i(a1), .d1_i(d1),
    .skip_i(skip), .err_i(err), .clr_i(clr), .susp_req_i(susp_req), .resume_i(resume),
    .busy_o(busy), .susp_o(susp), .status_o(status),
    .mem_we_o(mem_we), .mem_ers_o(mem_ers), .mem_addr_o(mem_addr), .mem_data_o(mem_data)
  );

  fci_array #(.ADDR_W(ADDR_W)) u_array (
    .clk_i, .rst_ni, .we_i(mem_we), .ers_i(mem_ers), .waddr_i(mem_addr),
    .wdata_i(mem_data), .raddr_i(addr_i), .rdata_o(mem_rd)
  );

  always_comb begin
    if (busy) rdata_o = status;
    else begin
      unique case (mode)
        RD_ARRAY: rdata_o = mem_rd;
        RD_STAT:  rdata_o = status;
        default:  rdata_o = addr_i[0] ? ID_DEV : ID_MFR;
      endcase
    end
  end

  assign busy_o = busy;

  // R9/R8: a program write never lands in a block the decoder treats as locked
  p_no_locked_prog_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we && !mem_ers) |-> !eff_lock[mem_addr[ADDR_W-1:OFS_W]]);
endmodule

// File: tb/sim_flash_cmd_if.sv
module sim_flash_cmd_if;
  localparam int NBLK_W = 4;
  localparam int OFS_W  = 4;
  localparam int WR_CYC = 6;
  localparam int BLK_B  = 1 << OFS_W;

  logic       clk = 1'b0, rst_ni = 1'b0, we_i = 1'b0, vpp_i = 1'b1;
  logic [7:0] addr_i = '0, data_i = '0;
  logic [7:0] rdata_o;
  logic       busy_o;
  int         nvec = 0, nerr = 0;
  bit         fin = 0;

  always #10 clk = ~clk;

  flash_cmd_if #(.NBLK_W(NBLK_W), .OFS_W(OFS_W), .WR_CYC(WR_CYC)) u0 (
    .clk_i(clk), .rst_ni, .we_i, .addr_i, .data_i, .vpp_i, .rdata_o, .busy_o
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nvec++;
    if (act !== exp) begin nerr++; $display("FAIL %s: got %02h want %02h", req, act, exp); end
  endtask

  task automatic chk_n(input string req, input int act, input int exp);
    nvec++;
    if (act != exp) begin nerr++; $display("FAIL %s: got %0d want %0d", req, act, exp); end
  endtask

  task automatic bw(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr_i = a; data_i = d; we_i = 1'b1;
    @(negedge clk); we_i = 1'b0;
  endtask

  task automatic cyc(output int n);
    n = 0;
    while (busy_o && n < 4000) begin @(negedge clk); n++; end
  endtask

  task automatic rd_st(output logic [7:0] v);
    bw(8'h00, 8'h70); #1 v = rdata_o;
  endtask

  task automatic rd_ar(input logic [7:0] a, output logic [7:0] v);
    bw(8'h00, 8'hFF); addr_i = a; #1 v = rdata_o;
  endtask

  task automatic prog(input logic [7:0] a, input logic [7:0] d, output int n);
    bw(8'h00, 8'h40); bw(a, d); cyc(n);
  endtask

  task automatic ers(input logic [7:0] a, output int n);
    bw(a, 8'h20); bw(a, 8'hD0); cyc(n);
  endtask

  task automatic do_reset();
    we_i = 1'b0; vpp_i = 1'b1; rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    logic [7:0] v;
    chk("R13 busy", {7'b0, busy_o}, 8'h00);
    addr_i = 8'h00; #1 chk("R13 array", rdata_o, 8'hFF);
    addr_i = 8'h5F; #1 chk("R2 array mode", rdata_o, 8'hFF);
    rd_st(v); chk("R13 status", v, 8'h80);
    bw(8'h00, 8'h90); addr_i = 8'h00; #1 chk("R2 id lo", rdata_o, 8'hB0);
    addr_i = 8'h01; #1 chk("R2 id hi", rdata_o, 8'h30);
  endtask

  task automatic t_lockout();
    logic [7:0] v; int n;
    prog(8'h21, 8'h00, n);
    chk_n("R8 no busy", n, 0);
    #1 chk("R8 prog refused", rdata_o, 8'h90);
    rd_ar(8'h21, v); chk("R8 data kept", v, 8'hFF);
    ers(8'h20, n);
    rd_st(v); chk("R8 erase refused", v, 8'hB0);
    rd_st(v); chk("R12 sticky", v, 8'hB0);
    bw(8'h00, 8'h50); rd_st(v); chk("R12 cleared", v, 8'h80);
  endtask

  task automatic t_erall_powerup();
    logic [7:0] v; int n;
    bw(8'h30, 8'h77); bw(8'h30, 8'hD0);
    bw(8'h00, 8'hA7); bw(8'h00, 8'hD0); cyc(n);
    chk_n("R10 erase-all cycles", n, 15 * BLK_B + 1);
    rd_st(v); chk("R10 no error", v, 8'h80);
    prog(8'h41, 8'h34, n);
    chk_n("R10 lockout lifted", n, WR_CYC);
    rd_ar(8'h41, v); chk("R10 prog after erase-all", v, 8'h34);
    prog(8'h35, 8'h12, n);
    rd_st(v); chk("R9 locked refused", v, 8'h90);
    bw(8'h00, 8'h50);
  endtask

  task automatic t_program();
    logic [7:0] v; int n;
    prog(8'h41, 8'hF0, n);
    chk_n("R3 prog cycles", n, WR_CYC);
    rd_ar(8'h41, v); chk("R3 and-program", v, 8'h30);
  endtask

  task automatic t_erase();
    logic [7:0] v; int n;
    prog(8'h50, 8'h11, n); prog(8'h60, 8'h22, n);
    ers(8'h5A, n);
    chk_n("R5 erase cycles", n, BLK_B);
    rd_ar(8'h50, v); chk("R5 erased lo", v, 8'hFF);
    rd_ar(8'h5F, v); chk("R5 erased hi", v, 8'hFF);
    rd_ar(8'h60, v); chk("R1 neighbour kept", v, 8'h22);
    bw(8'h60, 8'h20); bw(8'h60, 8'h55);
    rd_st(v); chk("R5 bad confirm", v, 8'hB0);
    rd_ar(8'h60, v); chk("R5 nothing erased", v, 8'h22);
    bw(8'h00, 8'h50);
  endtask

  task automatic t_two_byte();
    logic [7:0] v; int n;
    bw(8'h00, 8'hFB); bw(8'h72, 8'h5A); bw(8'h89, 8'hA5); cyc(n);
    chk_n("R6 two-byte cycles", n, 2 * WR_CYC);
    rd_ar(8'h72, v); chk("R6 first byte", v, 8'h5A);
    rd_ar(8'h89, v); chk("R6 second byte", v, 8'hA5);
  endtask

  task automatic t_busy_ignore();
    logic [7:0] v; int n;
    bw(8'h90, 8'h20); bw(8'h90, 8'hD0);
    #1 chk("R4 status while busy", rdata_o, 8'h00);
    bw(8'h00, 8'hFF); bw(8'h00, 8'h40); bw(8'hA3, 8'h00);
    #1 chk("R4 still status", rdata_o, 8'h00);
    cyc(n);
    rd_st(v); chk("R4 no error", v, 8'h80);
    rd_ar(8'hA3, v); chk("R4 write ignored", v, 8'hFF);
  endtask

  task automatic t_suspend();
    logic [7:0] v; int n;
    prog(8'hB0, 8'h00, n); prog(8'hC3, 8'h3C, n);
    bw(8'hB0, 8'h20); bw(8'hB0, 8'hD0);
    bw(8'h00, 8'hB0);
    #1 chk("R7 suspended status", rdata_o, 8'hC0);
    rd_ar(8'hC3, v); chk("R7 read other block", v, 8'h3C);
    repeat (20) @(negedge clk);
    rd_st(v); chk("R7 still suspended", v, 8'hC0);
    bw(8'h00, 8'hD0); cyc(n);
    chk("R7 resumed busy", {7'b0, n > 0}, 8'h01);
    rd_st(v); chk("R7 done status", v, 8'h80);
    rd_ar(8'hB0, v); chk("R7 erase completed", v, 8'hFF);
  endtask

  task automatic t_vpp();
    logic [7:0] v; int n;
    vpp_i = 1'b0;
    prog(8'hD0, 8'h00, n);
    rd_st(v); chk("R11 prog vpp", v, 8'h98);
    rd_ar(8'hD0, v); chk("R11 data kept", v, 8'hFF);
    ers(8'hD0, n);
    rd_st(v); chk("R11 erase vpp", v, 8'hB8);
    bw(8'h00, 8'h50); rd_st(v); chk("R12 clear", v, 8'h80);
    vpp_i = 1'b1;
  endtask

  task automatic t_protect();
    logic [7:0] v; int n;
    bw(8'h00, 8'h47); bw(8'h00, 8'hD0);
    prog(8'h35, 8'h12, n);
    rd_ar(8'h35, v); chk("R9 protect off", v, 8'h12);
    bw(8'h00, 8'h57); bw(8'h00, 8'hD0);
    prog(8'h36, 8'h00, n);
    rd_st(v); chk("R9 protect on", v, 8'h90);
    rd_ar(8'h36, v); chk("R9 locked kept", v, 8'hFF);
  endtask

  initial begin
    do_reset();
    t_reset_state();
    t_lockout();
    do_reset();
    t_erall_powerup();
    t_program();
    t_erase();
    t_two_byte();
    t_busy_ignore();
    t_suspend();
    t_vpp();
    t_protect();
    fin = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      nerr++;
      $display("FAIL watchdog: got hang want done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end
endmodule